// File: doc/BRIEF.md
# Network DMA FIFO with Threshold Bus Request

This block is a 16-byte staging buffer between the serial side of a network controller and its parallel memory bus. When receiving, the network side pushes bytes in. Once enough bytes have collected, the block raises a bus request and drains a fixed-length burst to memory. When transmitting, the memory side fills the buffer in bursts and the network side pops bytes out. A new burst is requested once the fill level has fallen far enough that a full burst fits.

The burst size comes from a 2-bit code and scales with the transfer width. In byte mode each memory transfer moves one byte on bits 7..0. In word mode each transfer moves two bytes packed into 16 bits, and a lane-swap bit selects the byte order. The block drives address bit 0, which alternates in byte mode and stays low in word mode. Pushing into a full buffer or popping from an empty one is dropped and latches a sticky flag. A change to the configuration inputs is held back until the buffer is empty and no granted burst is running.

Top module: `net_dma_fifo`

## Requirements
- R1: After reset, fill_level is 0, bus_req is 0, overrun and underrun are 0, and mem_a0 is 0.
- R2: In receive mode (cfg_tx=0), bus_req rises in the cycle after fill_level reaches the threshold T and stays low below it. T in bytes is 2, 4, 8 or 12 for cfg_thresh 0, 1, 2 or 3, and it is the same number of bytes in word mode (1, 2, 4 or 6 words).
- R3: In transmit mode (cfg_tx=1), bus_req rises in the cycle after fill_level is at or below 13 - T bytes, and stays low while fill_level is above that level.
- R4: A burst is T transfers in byte mode or T/2 transfers in word mode. One transfer takes place in each clock cycle in which bus_req and bus_gnt are both high. Each burst moves exactly T bytes, and bus_req falls after its last transfer.
- R5: Once raised, bus_req stays high while bus_gnt is low until its burst completes.
- R6: After a burst completes, bus_req is low for at least one cycle. It rises again in the following cycle if the trigger condition still holds.
- R7: In word mode with cfg_swap=0, the earlier byte of the stream sits on bits 7..0 of the memory word and the later byte on bits 15..8. This holds for both mem_rdata in receive and mem_wdata in transmit.
- R8: In word mode with cfg_swap=1, the earlier byte sits on bits 15..8 and the later byte on bits 7..0, in both directions.
- R9: In byte mode, cfg_swap has no effect. One byte is carried on bits 7..0, mem_rdata[15:8] reads 0, and mem_wdata[15:8] is not stored.
- R10: mem_a0 is 0 during every word-mode transfer. In byte mode it starts at 0 after reset and toggles after each transfer.
- R11: A net_push in receive mode while fill_level is 16 is dropped: fill_level stays at 16 and overrun becomes 1. The flag stays 1 until reset.
- R12: A net_pop in transmit mode while fill_level is 0 is dropped: fill_level stays at 0 and underrun becomes 1. The flag stays 1 until reset.
- R13: A change on the configuration inputs takes effect only in a cycle with fill_level 0 and no granted burst in progress. Until then the old threshold, width and direction stay in force.
- R14: net_pop in receive mode and net_push in transmit mode are ignored. fill_level does not change and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thresh | input | 2 | Threshold code |
| cfg_word | input | 1 | 1: 16-bit memory transfers, 0: byte transfers |
| cfg_swap | input | 1 | Byte-lane swap in word mode |
| cfg_tx | input | 1 | 1: transmit direction, 0: receive direction |
| net_push | input | 1 | Network byte push strobe (receive) |
| net_wdata | input | 8 | Byte pushed from the network |
| net_pop | input | 1 | Network byte pop strobe (transmit) |
| net_rdata | output | 8 | Oldest byte, presented to the network |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_wdata | input | 16 | Data from memory during a transmit transfer |
| mem_rdata | output | 16 | Data to memory during a receive transfer |
| mem_a0 | output | 1 | Memory address bit 0 |
| fill_level | output | 5 | Bytes held |
| overrun | output | 1 | Sticky push-when-full flag |
| underrun | output | 1 | Sticky pop-when-empty flag |

## Verification
The bench builds the block with its default parameters: a depth of 16 bytes and a transmit total of 13. With these values the largest code gives a 12-byte receive burst and a transmit trigger at a single byte, so both the highest receive trigger and the lowest transmit trigger are exercised. Sixteen pushes fill the buffer, so the next push reaches the overrun path. The trigger level falls on either side of the post-burst fill level depending on the code, so both an immediate re-request and a re-request after draining are seen.

// File: rtl/nd_pkg.sv
package nd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } nd_dir_e;

    typedef struct packed {
        logic [1:0] thr;
        logic       word;
        logic       swap;
        nd_dir_e    dir;
    } nd_cfg_t;
endpackage

// File: rtl/nd_thresh.sv
module nd_thresh #(
    parameter int DEPTH  = 16,
    parameter int TX_SUM = 13
) (
    input  logic [1:0]                   code,
    input  logic                         word,
    output logic [$clog2(DEPTH+1)-1:0]   thr_b,
    output logic [$clog2(DEPTH+1)-1:0]   units,
    output logic [$clog2(DEPTH+1)-1:0]   tx_lvl
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] thr_w;

    // Threshold counted in 16-bit words; the byte count is twice that.
    always_comb begin
        unique case (code)
            2'd0:    thr_w = CW'(1);
            2'd1:    thr_w = CW'(2);
            2'd2:    thr_w = CW'(4);
            default: thr_w = CW'(6);
        endcase
        thr_b  = thr_w << 1;
        units  = word ? thr_w : thr_b;
        tx_lvl = CW'(TX_SUM) - thr_b;
    end
endmodule

// File: rtl/nd_store.sv
module nd_store #(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  wr_cnt,
    input  logic [7:0]                  wr_b0,
    input  logic [7:0]                  wr_b1,
    input  logic [1:0]                  rd_cnt,
    output logic [7:0]                  rd_b0,
    output logic [7:0]                  rd_b1,
    output logic [$clog2(DEPTH+1)-1:0]  level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cnt != 2'd0) st_d.mem[st_q.wp] = wr_b0;
        if (wr_cnt == 2'd2) st_d.mem[st_q.wp + AW'(1)] = wr_b1;
        st_d.wp  = st_q.wp + AW'(wr_cnt);
        st_d.rp  = st_q.rp + AW'(rd_cnt);
        st_d.cnt = st_q.cnt + CW'(wr_cnt) - CW'(rd_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_b0 = st_q.mem[st_q.rp];
    assign rd_b1 = st_q.mem[st_q.rp + AW'(1)];
    assign level = st_q.cnt;
endmodule

// File: rtl/nd_burst.sv
module nd_burst #(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dir_tx,
    input  logic [$clog2(DEPTH+1)-1:0]  fill,
    input  logic [$clog2(DEPTH+1)-1:0]  thr_b,
    input  logic [$clog2(DEPTH+1)-1:0]  units,
    input  logic [$clog2(DEPTH+1)-1:0]  tx_lvl,
    input  logic                        gnt,
    input  logic                        cfg_apply,
    output logic                        req,
    output logic                        xfer,
    output logic                        active
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          req;
        logic          act;
        logic [CW-1:0] cnt;
    } bs_t;

    bs_t bs_d, bs_q;
    logic trig;

    always_comb begin
        bs_d = bs_q;
        xfer = bs_q.req & gnt;
        trig = dir_tx ? (fill <= tx_lvl) : (fill >= thr_b);
        if (xfer) begin
            if (bs_q.cnt == units - CW'(1)) begin
                bs_d.req = 1'b0;
                bs_d.act = 1'b0;
                bs_d.cnt = '0;
            end else begin
                bs_d.act = 1'b1;
                bs_d.cnt = bs_q.cnt + CW'(1);
            end
        end else if (cfg_apply) begin
            bs_d.req = 1'b0;
        end else if (!bs_q.req && trig) begin
            bs_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign req    = bs_q.req;
    assign active = bs_q.act;
endmodule

// File: rtl/net_dma_fifo.sv
module net_dma_fifo
    import nd_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TX_SUM = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cfg_thresh,
    input  logic                        cfg_word,
    input  logic                        cfg_swap,
    input  logic                        cfg_tx,
    input  logic                        net_push,
    input  logic [7:0]                  net_wdata,
    input  logic                        net_pop,
    output logic [7:0]                  net_rdata,
    output logic                        bus_req,
    input  logic                        bus_gnt,
    input  logic [15:0]                 mem_wdata,
    output logic [15:0]                 mem_rdata,
    output logic                        mem_a0,
    output logic [$clog2(DEPTH+1)-1:0]  fill_level,
    output logic                        overrun,
    output logic                        underrun
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        nd_cfg_t cfg;
        logic    a0;
        logic    ovr;
        logic    udr;
    } top_st_t;

    top_st_t top_d, top_q;
    nd_cfg_t cfg_in;

    logic [CW-1:0] fill, thr_b, units, tx_lvl;
    logic          xfer, active, cfg_apply, is_tx, is_word, push_ok, pop_ok;
    logic [1:0]    wr_cnt, rd_cnt, xfer_n;
    logic [7:0]    wr_b0, wr_b1, rd_b0, rd_b1;
    logic          cfg_word_q, cfg_tx_q;
    logic [$bits(nd_cfg_t)-1:0] cfg_bits_q;

    nd_thresh #(.DEPTH(DEPTH), .TX_SUM(TX_SUM)) thr_i (
        .code   (top_q.cfg.thr),
        .word   (top_q.cfg.word),
        .thr_b  (thr_b),
        .units  (units),
        .tx_lvl (tx_lvl)
    );

    nd_store #(.DEPTH(DEPTH)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cnt (wr_cnt),
        .wr_b0  (wr_b0),
        .wr_b1  (wr_b1),
        .rd_cnt (rd_cnt),
        .rd_b0  (rd_b0),
        .rd_b1  (rd_b1),
        .level  (fill)
    );

    nd_burst #(.DEPTH(DEPTH)) burst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_tx    (is_tx),
        .fill      (fill),
        .thr_b     (thr_b),
        .units     (units),
        .tx_lvl    (tx_lvl),
        .gnt       (bus_gnt),
        .cfg_apply (cfg_apply),
        .req       (bus_req),
        .xfer      (xfer),
        .active    (active)
    );

    always_comb begin
        cfg_in.thr  = cfg_thresh;
        cfg_in.word = cfg_word;
        cfg_in.swap = cfg_swap;
        cfg_in.dir  = cfg_tx ? DIR_TX : DIR_RX;

        is_tx   = (top_q.cfg.dir == DIR_TX);
        is_word = top_q.cfg.word;

        // New settings land only on an empty buffer with no burst under way.
        cfg_apply = (cfg_in != top_q.cfg) && (fill == '0) && !active && !xfer;

        push_ok = !is_tx && net_push && (fill != CW'(DEPTH));
        pop_ok  = is_tx && net_pop && (fill != '0);
        xfer_n  = xfer ? (is_word ? 2'd2 : 2'd1) : 2'd0;

        if (is_tx) begin
            wr_cnt = xfer_n;
            rd_cnt = {1'b0, pop_ok};
            wr_b0  = (is_word && top_q.cfg.swap) ? mem_wdata[15:8] : mem_wdata[7:0];
            wr_b1  = (is_word && top_q.cfg.swap) ? mem_wdata[7:0]  : mem_wdata[15:8];
        end else begin
            wr_cnt = {1'b0, push_ok};
            rd_cnt = xfer_n;
            wr_b0  = net_wdata;
            wr_b1  = 8'h00;
        end

        if (!is_word)            mem_rdata = {8'h00, rd_b0};
        else if (top_q.cfg.swap) mem_rdata = {rd_b0, rd_b1};
        else                     mem_rdata = {rd_b1, rd_b0};

        top_d     = top_q;
        top_d.ovr = top_q.ovr | (!is_tx && net_push && (fill == CW'(DEPTH)));
        top_d.udr = top_q.udr | (is_tx && net_pop && (fill == '0));
        top_d.a0  = top_q.a0 ^ (xfer && !is_word);
        if (cfg_apply) top_d.cfg = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign net_rdata  = rd_b0;
    assign mem_a0     = top_q.a0 & !is_word;
    assign fill_level = fill;
    assign overrun    = top_q.ovr;
    assign underrun   = top_q.udr;
    assign cfg_word_q = is_word;
    assign cfg_tx_q   = is_tx;
    assign cfg_bits_q = top_q.cfg;
endmodule

// File: rtl/nd_fifo_chk.sv
module nd_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(DEPTH+1)-1:0]  fill_level,
    input logic                        bus_req,
    input logic                        bus_gnt,
    input logic                        net_push,
    input logic                        overrun,
    input logic                        underrun,
    input logic                        mem_a0,
    input logic                        cfg_word_q,
    input logic                        cfg_tx_q,
    input logic [4:0]                  cfg_bits_q,
    input logic                        cfg_apply
);
    // R5: a pending request is not withdrawn while waiting for the grant
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && !cfg_apply |=> bus_req);

    // R11: push into a full buffer raises the overrun flag
    a_r11_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == DEPTH) && net_push && !cfg_tx_q |=> overrun);

    // R11: the level never exceeds the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= DEPTH);

    // R11, R12: flags are sticky
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r12_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R10: each byte-mode transfer flips address bit 0
    a_r10_a0_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && !cfg_word_q |=> mem_a0 != $past(mem_a0));

    // R13: settings hold while data remains in the buffer
    a_r13_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level != 0 |=> $stable(cfg_bits_q));
endmodule

bind net_dma_fifo nd_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .net_push   (net_push),
    .overrun    (overrun),
    .underrun   (underrun),
    .mem_a0     (mem_a0),
    .cfg_word_q (cfg_word_q),
    .cfg_tx_q   (cfg_tx_q),
    .cfg_bits_q (cfg_bits_q),
    .cfg_apply  (cfg_apply)
);

// File: tb/net_dma_fifo_tb_top.sv
module net_dma_fifo_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam int TXS   = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_thresh;
    logic        cfg_word, cfg_swap, cfg_tx;
    logic        net_push, net_pop, bus_gnt;
    logic [7:0]  net_wdata, net_rdata;
    logic        bus_req, mem_a0, overrun, underrun;
    logic [15:0] mem_wdata, mem_rdata;
    logic [4:0]  fill_level;

    int   n_chk = 0;
    int   n_err = 0;
    logic [7:0] q[$];
    logic ea0;

    always #(CLK_P/2) clk = ~clk;

    net_dma_fifo #(.DEPTH(DEPTH), .TX_SUM(TXS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_word(cfg_word),
        .cfg_swap(cfg_swap), .cfg_tx(cfg_tx), .net_push(net_push), .net_wdata(net_wdata),
        .net_pop(net_pop), .net_rdata(net_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_a0(mem_a0),
        .fill_level(fill_level), .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int thr_of(int code);
        case (code)
            0:       return 2;
            1:       return 4;
            2:       return 8;
            default: return 12;
        endcase
    endfunction

    task automatic do_reset(int code, bit word, bit swap, bit tx);
        cfg_thresh = 2'(code); cfg_word = word; cfg_swap = swap; cfg_tx = tx;
        net_push = 0; net_pop = 0; bus_gnt = 0; net_wdata = 0; mem_wdata = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        q.delete();
        ea0 = 0;
    endtask

    task automatic push(logic [7:0] b, bit model);
        net_wdata = b; net_push = 1;
        if (model) q.push_back(b);
        @(negedge clk);
        net_push = 0;
    endtask

    task automatic pop_chk(string tag);
        chk({tag, " network byte order"}, net_rdata, q[0]);
        net_pop = 1;
        @(negedge clk);
        net_pop = 0;
        void'(q.pop_front());
    endtask

    task automatic rx_burst(int units, bit word, bit swap, string tag);
        int n = 0;
        logic [15:0] e;
        bus_gnt = 1;
        while (bus_req && n < 40) begin
            if (word) e = swap ? {q[0], q[1]} : {q[1], q[0]};
            else      e = {8'h00, q[0]};
            chk({tag, " memory word"}, mem_rdata, e);
            chk("R10 address bit 0", mem_a0, word ? 0 : ea0);
            void'(q.pop_front());
            if (word) void'(q.pop_front());
            else      ea0 = ~ea0;
            n++;
            @(negedge clk);
        end
        bus_gnt = 0;
        chk("R4 receive burst length", n, units);
    endtask

    task automatic tx_burst(int units, bit word, bit swap);
        int n = 0;
        logic [7:0] hi, lo;
        bus_gnt = 1;
        while (bus_req && n < 40) begin
            hi = 8'(8'hD0 + n); lo = 8'(8'h50 + n);
            mem_wdata = {hi, lo};
            chk("R10 address bit 0", mem_a0, word ? 0 : ea0);
            if (!word)     begin q.push_back(lo); ea0 = ~ea0; end
            else if (swap) begin q.push_back(hi); q.push_back(lo); end
            else           begin q.push_back(lo); q.push_back(hi); end
            n++;
            @(negedge clk);
        end
        bus_gnt = 0;
        chk("R4 transmit burst length", n, units);
    endtask

    task automatic t_reset();
        do_reset(0, 0, 0, 0);
        chk("R1 fill after reset", fill_level, 0);
        chk("R1 request after reset", bus_req, 0);
        chk("R1 overrun after reset", overrun, 0);
        chk("R1 underrun after reset", underrun, 0);
        chk("R1 a0 after reset", mem_a0, 0);
    endtask

    task automatic t_rx_thr(int code, bit word, bit swap);
        int thr = thr_of(code);
        string tag = word ? (swap ? "R8" : "R7") : "R9";
        do_reset(code, word, swap, 0);
        for (int i = 0; i < thr - 1; i++) push(8'(8'h20 + code * 16 + i), 1);
        repeat (2) @(negedge clk);
        chk("R2 request below threshold", bus_req, 0);
        push(8'(8'h20 + code * 16 + thr - 1), 1);
        @(negedge clk);
        chk("R2 request at threshold", bus_req, 1);
        repeat (2) @(negedge clk);
        chk("R5 request held without grant", bus_req, 1);
        rx_burst(word ? thr / 2 : thr, word, swap, tag);
        chk("R4 fill after receive burst", fill_level, 0);
    endtask

    task automatic t_gap();
        do_reset(0, 0, 0, 0);
        for (int i = 0; i < 5; i++) push(8'(8'h90 + i), 1);
        rx_burst(2, 0, 0, "R9");
        chk("R6 request low after burst", bus_req, 0);
        @(negedge clk);
        chk("R6 request raised again", bus_req, 1);
        chk("R4 fill after partial drain", fill_level, 3);
    endtask

    task automatic t_tx(int code, bit word, bit swap);
        int thr = thr_of(code);
        int lvl = TXS - thr;
        string tag = word ? (swap ? "R8" : "R7") : "R9";
        do_reset(code, word, swap, 1);
        chk("R3 request on empty transmit buffer", bus_req, 1);
        repeat (2) @(negedge clk);
        chk("R5 request held without grant", bus_req, 1);
        tx_burst(word ? thr / 2 : thr, word, swap);
        chk("R4 fill after transmit burst", fill_level, thr);
        @(negedge clk);
        chk("R3 request after transmit burst", bus_req, (thr <= lvl) ? 1 : 0);
        if (thr > lvl) begin
            while (q.size() > lvl + 1) pop_chk(tag);
            repeat (2) @(negedge clk);
            chk("R3 request above transmit level", bus_req, 0);
            pop_chk(tag);
            @(negedge clk);
            chk("R3 request at transmit level", bus_req, 1);
        end
        while (q.size() > 0) pop_chk(tag);
        chk("R12 no underrun on normal drain", underrun, 0);
    endtask

    task automatic t_overrun();
        do_reset(3, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i), 1);
        chk("R11 fill at depth", fill_level, DEPTH);
        push(8'hEE, 0);
        chk("R11 fill after push when full", fill_level, DEPTH);
        chk("R11 overrun set", overrun, 1);
        chk("R11 underrun untouched", underrun, 0);
        repeat (3) @(negedge clk);
        chk("R11 overrun sticky", overrun, 1);
    endtask

    task automatic t_underrun();
        do_reset(0, 0, 0, 1);
        net_pop = 1;
        @(negedge clk);
        net_pop = 0;
        chk("R12 fill after pop when empty", fill_level, 0);
        chk("R12 underrun set", underrun, 1);
        chk("R12 overrun untouched", overrun, 0);
        repeat (3) @(negedge clk);
        chk("R12 underrun sticky", underrun, 1);
    endtask

    task automatic t_wrong_dir();
        do_reset(3, 0, 0, 0);
        for (int i = 0; i < 3; i++) push(8'(8'h70 + i), 1);
        net_pop = 1;
        @(negedge clk);
        net_pop = 0;
        chk("R14 pop ignored in receive", fill_level, 3);
        chk("R14 no underrun in receive", underrun, 0);
        do_reset(0, 0, 0, 1);
        push(8'h77, 0);
        chk("R14 push ignored in transmit", fill_level, 0);
        chk("R14 no overrun in transmit", overrun, 0);
    endtask

    task automatic t_cfg_defer();
        do_reset(3, 0, 0, 0);
        for (int i = 0; i < 3; i++) push(8'(8'hA0 + i), 1);
        cfg_thresh = 2'd0;
        repeat (3) @(negedge clk);
        chk("R13 old threshold kept while not empty", bus_req, 0);
        for (int i = 3; i < 12; i++) push(8'(8'hA0 + i), 1);
        @(negedge clk);
        chk("R13 request at old threshold", bus_req, 1);
        rx_burst(12, 0, 0, "R13");
        repeat (2) @(negedge clk);
        push(8'hB0, 1);
        @(negedge clk);
        chk("R13 new threshold not yet met", bus_req, 0);
        push(8'hB1, 1);
        @(negedge clk);
        chk("R13 new threshold applied", bus_req, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0;
        t_reset();
        t_rx_thr(0, 0, 1);
        t_rx_thr(1, 0, 0);
        t_rx_thr(2, 0, 0);
        t_rx_thr(3, 0, 0);
        t_rx_thr(1, 1, 0);
        t_rx_thr(1, 1, 1);
        t_rx_thr(3, 1, 1);
        t_gap();
        t_tx(0, 0, 0);
        t_tx(3, 0, 1);
        t_tx(1, 1, 1);
        t_tx(2, 1, 0);
        t_overrun();
        t_underrun();
        t_wrong_dir();
        t_cfg_defer();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule